// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous system port and an external asynchronous static RAM of 256K sixteen-bit words. Each lane has its own active-low select: lane 0 covers data bits 7:0 and lane 1 covers bits 15:8. A system master offers one request at a time: an address, a read/write flag, write data and a per-lane enable mask. The block answers with a ready handshake and, for reads, a one-cycle valid strobe carrying the captured word.

On the memory side the block drives registered control pins: chip select, write enable, output enable and the lane selects, all active low. It also drives the address and the outgoing data, and switches a shared data bus through a driver-enable output. The length of each access phase is a whole number of clock cycles. That number comes from a clock-period parameter and a speed-grade parameter, so the same logic can be used at several clock rates. The address never moves during an access. The block orders the bus hand-over so that it and the memory never drive the data lines together.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, chip select, write enable, output enable and every lane select are high. The data driver is off, `ready` is high and `rvalid` is low.
- R2: A read holds chip select and output enable low and write enable high, with low selects on exactly the lanes whose `mask` bit is 1 (bit 0 is bits 7:0, bit 1 is bits 15:8). In `rdata`, enabled lanes carry the memory word and disabled lanes read as zero.
- R3: A write holds chip select low and output enable high. Write enable is low only while the data driver is on, and only lanes whose `mask` bit is 1 are selected. A lane whose mask bit is 0, including every lane of an all-zero mask, keeps its old memory contents.
- R4: `mem_addr` does not change in any cycle where chip select was low in the cycle before and is still low.
- R5: The data driver is never on while output enable is low. Write enable is never low unless chip select is low and output enable is high.
- R6: When a write follows a read, the data driver stays off and output enable stays high for at least two whole cycles after output enable rises. Those two cycles are the float wait and one idle cycle.
- R7: The data driver turns off only after write enable has already been high for at least one cycle.
- R8: For each read, `rvalid` is high for exactly one cycle. It rises RD cycles after the accepting clock edge, where RD is the read wait count.
- R9: A request is accepted only on a clock edge where `ready` is high. `ready` is low from the cycle after acceptance until the access ends. A request presented while `ready` is low has no effect.
- R10: Each wait count equals the phase's minimum time divided by the clock period, rounded up, and is at least 1. With the default 10 ns clock and the slowest grade, the read phase has output enable low for 2 cycles and the write pulse has write enable low for 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid |
| ready | output | 1 | High when a request can be accepted |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| mask | input | DATA_W/8 | Lane enables, bit 0 = low byte |
| rdata | output | DATA_W | Read data, disabled lanes zero |
| rvalid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | DATA_W/8 | Lane selects, active low, bit 0 = low byte |
| mem_dq_out | output | DATA_W | Outgoing data for the shared bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | DATA_W | Incoming data from the shared bus |

## Verification
Writes are issued with full, low-only, high-only and empty masks, and each result is read back through the full mask. These runs separate a lane that is wrongly selected from one that correctly keeps its old byte. Reads with single-lane masks show that a lane which is not selected reads as zero and is not passed through. A read immediately followed by a write exposes a missing float or idle cycle before the driver turns on. A write request pulsed while a read is in progress must leave the targeted word unchanged. Cycle counts of output-enable-low and write-enable-low, together with the read strobe latency, confirm the derived wait counts.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WEND
    } seq_st_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctl_t;

    // Minimum times in picoseconds, grade 0 fastest, grade 2 slowest
    function automatic int unsigned t_read_ps(int unsigned grade);
        case (grade)
            0:       return 8000;
            1:       return 10000;
            default: return 12000;
        endcase
    endfunction

    function automatic int unsigned t_wp_ps(int unsigned grade);
        case (grade)
            0:       return 6000;
            1:       return 7000;
            default: return 8000;
        endcase
    endfunction

    function automatic int unsigned t_hz_ps(int unsigned grade);
        case (grade)
            0:       return 4000;
            1:       return 5000;
            default: return 6000;
        endcase
    endfunction

    function automatic int unsigned wait_cycles(int unsigned t_ps, int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic pin_ctl_t ctl_for(seq_st_t s);
        pin_ctl_t p;
        p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (s)
            ST_RD:   begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            ST_WSET: begin p.cs_n = 1'b0; p.drive = 1'b1; end
            ST_WPUL: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
            ST_WEND: begin p.drive = 1'b1; end
            default: ;
        endcase
        return p;
    endfunction

    function automatic logic lanes_active(seq_st_t s);
        return (s == ST_RD) || (s == ST_WSET) || (s == ST_WPUL);
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned RD_CYC = 2,
    parameter int unsigned WP_CYC = 1,
    parameter int unsigned HZ_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic             tmr_last,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_st_t          nxt
);
    seq_st_t st_q;

    assign ready  = (st_q == ST_IDLE);
    assign accept = ready && req;

    always_comb begin
        nxt      = st_q;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_IDLE: if (req) begin
                if (wr) begin
                    nxt = ST_WSET;
                end else begin
                    nxt      = ST_RD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RD_CYC);
                end
            end
            ST_RD: if (tmr_last) begin
                nxt      = ST_TURN;
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HZ_CYC);
            end
            ST_TURN: if (tmr_last) nxt = ST_IDLE;
            ST_WSET: begin
                nxt      = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC);
            end
            ST_WPUL: if (tmr_last) nxt = ST_WEND;
            ST_WEND: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= nxt;
    end
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DW    = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  seq_st_t           nxt,
    input  logic              capture,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DW-1:0]     usr_wdata,
    input  logic [LANES-1:0]  usr_mask,
    input  logic [DW-1:0]     dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_bsel_n,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    pin_ctl_t          ctl_q;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  mask_nx;
    logic              lane_on;

    assign mask_nx = accept ? usr_mask : mask_q;
    assign lane_on = lanes_active(nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            mem_addr <= '0;
            dq_out   <= '0;
            mask_q   <= '0;
            rvalid   <= 1'b0;
        end else begin
            ctl_q  <= ctl_for(nxt);
            rvalid <= capture;
            if (accept) begin
                mem_addr <= usr_addr;
                dq_out   <= usr_wdata;
                mask_q   <= usr_mask;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_bsel_n[g]            <= 1'b1;
                rdata[g*BYTE_W +: BYTE_W] <= '0;
            end else begin
                mem_bsel_n[g] <= !(lane_on && mask_nx[g]);
                if (capture)
                    rdata[g*BYTE_W +: BYTE_W] <= mask_q[g] ? dq_in[g*BYTE_W +: BYTE_W] : '0;
            end
        end
    end

    assign mem_cs_n = ctl_q.cs_n;
    assign mem_we_n = ctl_q.we_n;
    assign mem_oe_n = ctl_q.oe_n;
    assign dq_oe    = ctl_q.drive;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CLK_PS = 10000,
    parameter int unsigned GRADE  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    output logic                     ready,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/8-1:0]      mask,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rvalid,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_cs_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/8-1:0]      mem_bsel_n,
    output logic [DATA_W-1:0]        mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_in
);
    localparam int unsigned LANES   = DATA_W / BYTE_W;
    localparam int unsigned RD_CYC  = wait_cycles(t_read_ps(GRADE), CLK_PS);
    localparam int unsigned WP_CYC  = wait_cycles(t_wp_ps(GRADE), CLK_PS);
    localparam int unsigned HZ_CYC  = wait_cycles(t_hz_ps(GRADE), CLK_PS);
    localparam int unsigned MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > HZ_CYC) ? MAX_A : HZ_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    seq_st_t          nxt;
    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic             tmr_last;
    logic [CNT_W-1:0] tmr_val;

    sram_seq_fsm #(
        .CNT_W (CNT_W),
        .RD_CYC(RD_CYC),
        .WP_CYC(WP_CYC),
        .HZ_CYC(HZ_CYC)
    ) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wr      (wr),
        .tmr_last(tmr_last),
        .ready   (ready),
        .accept  (accept),
        .capture (capture),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val),
        .nxt     (nxt)
    );

    sram_wait_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    sram_lane_io #(.ADDR_W(ADDR_W), .LANES(LANES)) io_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .nxt       (nxt),
        .capture   (capture),
        .usr_addr  (addr),
        .usr_wdata (wdata),
        .usr_mask  (mask),
        .dq_in     (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_bsel_n(mem_bsel_n),
        .dq_out    (mem_dq_out),
        .dq_oe     (mem_dq_oe),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned LANES  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              ready,
    input logic              rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_bsel_n,
    input logic              mem_dq_oe
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (mem_cs_n && mem_we_n && mem_oe_n && (&mem_bsel_n)
                 && !mem_dq_oe && ready && !rvalid));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    assert_we_gated_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    assert_we_needs_drive_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

    assert_release_after_we_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_oe) |-> $past(mem_we_n));

    assert_rvalid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .ready     (ready),
    .rvalid    (rvalid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_bsel_n(mem_bsel_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
    // R10: slowest grade, 10 ns clock -> read 12/10 -> 2, pulse 8/10 -> 1
    localparam int RD_EXP = 2;
    localparam int WP_EXP = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr  = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  mask = '0;
    logic        ready, rvalid;
    logic [15:0] rdata;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_bsel_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_lane_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .wr(wr),
        .addr(addr), .wdata(wdata), .mask(mask), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model, indexed by the low 10 address bits
    logic [15:0] mem [0:1023];
    initial for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;

    always_comb begin
        mem_dq_in = 16'hA5A5;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            if (!mem_bsel_n[0]) mem_dq_in[7:0]  = mem[mem_addr[9:0]][7:0];
            if (!mem_bsel_n[1]) mem_dq_in[15:8] = mem[mem_addr[9:0]][15:8];
        end
    end

    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n) begin
            for (int l = 0; l < 2; l++)
                if (!mem_bsel_n[l])
                    mem[mem_addr[9:0]][l*8 +: 8] <= mem_dq_oe ? mem_dq_out[l*8 +: 8] : 8'hEE;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // monitors, sampled away from the active edge
    int          oe_low_cnt = 0;
    int          we_low_cnt = 0;
    logic [1:0]  we_lanes   = 2'b11;
    int          quiet      = 99;
    logic        prev_drive = 1'b0;
    logic        prev_we_n  = 1'b1;
    logic        prev_cs_n  = 1'b1;
    logic [17:0] prev_addr  = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_oe_n) oe_low_cnt++;
            if (!mem_we_n) begin we_low_cnt++; we_lanes = mem_bsel_n; end
            if (mem_dq_oe && !mem_oe_n) chk(0, "R5", 1, 0);
            if (!mem_cs_n && !prev_cs_n && mem_addr != prev_addr)
                chk(0, "R4", mem_addr, prev_addr);
            if (mem_dq_oe && !prev_drive) chk(quiet >= 2, "R6", quiet, 2);
            if (!mem_dq_oe && prev_drive) chk(prev_we_n, "R7", prev_we_n, 1);
            if (!mem_oe_n) quiet = 0;
            else if (!mem_dq_oe && quiet < 99) quiet++;
        end
        prev_drive = mem_dq_oe;
        prev_we_n  = mem_we_n;
        prev_cs_n  = mem_cs_n;
        prev_addr  = mem_addr;
    end

    task automatic wait_ready();
        int guard = 0;
        while (!ready && guard < 50) begin @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(mem_bsel_n == 2'b11, "R1", mem_bsel_n, 2'b11);
        chk(!mem_dq_oe && ready && !rvalid, "R1", {mem_dq_oe, ready, rvalid}, 3'b010);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe && ready, "R1", {mem_cs_n, mem_dq_oe, ready}, 3'b101);
    endtask

    task automatic t_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        we_low_cnt = 0;
        we_lanes   = 2'b11;
        req = 1'b1; wr = 1'b1; addr = a; wdata = d; mask = m;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        chk(!ready, "R9", ready, 0);
        wait_ready();
        chk(we_low_cnt == WP_EXP, "R10", we_low_cnt, WP_EXP);
        if (m != 2'b00) chk(we_lanes == ~m, "R3", we_lanes, ~m);
    endtask

    task automatic t_read(input logic [17:0] a, input logic [1:0] m, input logic [15:0] exp);
        int lat = 0;
        oe_low_cnt = 0;
        req = 1'b1; wr = 1'b0; addr = a; mask = m;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        chk(!ready, "R9", ready, 0);
        while (!rvalid && lat < 20) begin @(negedge clk); lat++; end
        chk(lat == RD_EXP, "R8", lat, RD_EXP);
        chk(rdata == exp, "R2", rdata, exp);
        @(negedge clk);
        chk(!rvalid, "R8", rvalid, 0);
        wait_ready();
        chk(oe_low_cnt == RD_EXP, "R10", oe_low_cnt, RD_EXP);
    endtask

    task automatic t_busy_ignored();
        int lat = 0;
        req = 1'b1; wr = 1'b0; addr = 18'h3_0200; mask = 2'b11;
        @(posedge clk);
        @(negedge clk);
        // write request while busy must be ignored (R9)
        wr = 1'b1; addr = 18'h2_0010; wdata = 16'hFFFF; mask = 2'b11;
        @(negedge clk);
        req = 1'b0;
        while (!rvalid && lat < 20) begin @(negedge clk); lat++; end
        chk(rdata == 16'h5A5A, "R2", rdata, 16'h5A5A);
        wait_ready();
        @(negedge clk);
        t_read(18'h2_0010, 2'b11, 16'h7722);
    endtask

    initial begin
        t_reset();
        t_write(18'h2_0010, 16'hBEEF, 2'b11);
        t_read (18'h2_0010, 2'b11, 16'hBEEF);
        t_write(18'h2_0010, 16'h1122, 2'b01);          // R3 low lane only
        t_read (18'h2_0010, 2'b11, 16'hBE22);
        t_write(18'h2_0010, 16'h7700, 2'b10);          // R3 high lane only
        t_read (18'h2_0010, 2'b01, 16'h0022);          // R2 upper lane zero
        t_read (18'h2_0010, 2'b10, 16'h7700);          // R2 lower lane zero
        t_write(18'h2_0010, 16'hFFFF, 2'b00);          // R3 empty mask
        t_read (18'h2_0010, 2'b11, 16'h7722);
        t_write(18'h3_0200, 16'h5A5A, 2'b11);
        t_busy_ignored();
        // R6: read followed at once by a write
        t_read (18'h3_0200, 2'b11, 16'h5A5A);
        t_write(18'h3_0200, 16'hC3C3, 2'b11);
        t_read (18'h3_0200, 2'b11, 16'hC3C3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(0, "R9", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule